// File: doc/BRIEF.md
# Waveform Trace Raster Renderer

This block draws a stored waveform as a line trace on a raster display. Time runs along the horizontal axis and sample value along the vertical axis. Each frame starts from a base address, which is captured only at the frame boundary. The block fetches the half-line's worth of samples from bulk memory through an in-order request/response port. The samples go into a small local buffer with one write port and two read ports, so fetching and pixel generation run at the same time.

Pixels leave in raster order, top row first and left to right, through a valid/ready port to a video encoder. Two adjacent pixel columns share one sample. A pixel is painted in the trace colour when its vertical level lies between the current and preceding samples' scaled levels. Every other pixel takes a background whose blue shade grows toward the bottom of the screen. Pixels are computed only when the encoder can take them, and a column whose sample has not yet arrived simply waits.

Top module: `wfr_render`

## Requirements
- R1: While reset is asserted, out_valid and mem_req_valid are both low.
- R2: In each frame the block issues exactly H_ACT/2 memory requests, at addresses base, base+1, … in that order. A request whose mem_req_ready is low stays valid with an unchanged address.
- R3: The base address is taken from frame_base only in the cycle that opens a frame. A change of frame_base during a frame has no effect on that frame's requests or pixels.
- R4: Each frame is H_ACT × 2^VBITS pixels in raster order: row 0 (top) first, and within a row column 0 first.
- R5: Column c displays sample index c>>1 of the window, so every sample covers two adjacent columns.
- R6: A sample's vertical level is its top VBITS bits, and row r corresponds to level 2^VBITS−1−r, so larger values appear higher on screen.
- R7: A pixel gets the TRACE colour (default 12'hFF0) when its level lies inclusively between the level of its own sample and the level of the previous sample. For sample index 0 the previous sample is the sample itself.
- R8: Colour words are 12 bits, with red in [11:8], green in [7:4] and blue in [3:0]. Background pixels have red = green = 0 and blue = row·16/2^VBITS.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_pix stays unchanged.
- R10: A pixel of the top row is never presented before the response carrying its sample has arrived. Slow memory stalls the output but never changes pixel values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_base | input | AW | Window start address, captured at frame start |
| mem_req_valid | output | 1 | Sample read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Sample read address |
| mem_rsp_valid | input | 1 | Read data returned (in request order) |
| mem_rsp_data | input | SW | Returned sample value |
| out_valid | output | 1 | Pixel word valid |
| out_ready | input | 1 | Encoder takes the pixel |
| out_pix | output | 12 | Pixel colour word |

## Verification
The bound checker watches, on every cycle, the properties that counters can track. These are: the reset-idle outputs, the pixel held stable under backpressure, the request held stable and capped at one window per frame, the top-row pixel that cannot overtake its sample's response, and the frame length at each frame boundary. Pixel colours, the trace-versus-gradient decision, the two-columns-per-sample mapping and the address sequence depend on the sample values. The bench's scenarios show these by comparing every pixel and every request address against a model. They also show that a base change in mid-frame waits for the next frame, under random memory latency and random encoder stalls.

// File: rtl/wfr_pkg.sv
package wfr_pkg;
    localparam int CH_W = 4;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    function automatic rgb_t bg_color(input logic [CH_W-1:0] shade);
        rgb_t c;
        c.r = '0;
        c.g = '0;
        c.b = shade;
        return c;
    endfunction
endpackage

// File: rtl/wfr_sample_buf.sv
module wfr_sample_buf #(
    parameter int DEPTH = 360,
    parameter int SW    = 8,
    localparam int IXW  = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           we,
    input  logic [IXW-1:0] wa,
    input  logic [SW-1:0]  wd,
    input  logic [IXW-1:0] ra_cur,
    input  logic [IXW-1:0] ra_prv,
    output logic [SW-1:0]  rd_cur,
    output logic [SW-1:0]  rd_prv
);
    logic [SW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[wa] <= wd;
    end

    assign rd_cur = mem_q[ra_cur];
    assign rd_prv = mem_q[ra_prv];
endmodule

// File: rtl/wfr_fetch.sv
module wfr_fetch #(
    parameter int AW    = 24,
    parameter int N     = 360,
    localparam int CNTW = $clog2(N + 1),
    localparam int IXW  = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   frame_base,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [AW-1:0]   mem_req_addr,
    input  logic            mem_rsp_valid,
    output logic            wr_en,
    output logic [IXW-1:0]  wr_idx,
    output logic [CNTW-1:0] fill
);
    typedef struct packed {
        logic [AW-1:0]   base;
        logic [CNTW-1:0] req;
        logic [CNTW-1:0] fill;
    } fetch_t;

    fetch_t st_d, st_q;

    assign mem_req_valid = !start && (st_q.req < CNTW'(N));
    assign mem_req_addr  = st_q.base + AW'(st_q.req);
    assign wr_en         = mem_rsp_valid && !start && (st_q.fill < CNTW'(N));
    assign wr_idx        = st_q.fill[IXW-1:0];
    assign fill          = st_q.fill;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.base = frame_base;
            st_d.req  = '0;
            st_d.fill = '0;
        end else begin
            if (mem_req_valid && mem_req_ready) st_d.req  = st_q.req + 1'b1;
            if (wr_en)                          st_d.fill = st_q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wfr_pixel_color.sv
module wfr_pixel_color
    import wfr_pkg::*;
#(
    parameter int          VBITS = 8,
    parameter int          SW    = 8,
    parameter logic [11:0] TRACE = 12'hFF0
) (
    input  logic [VBITS-1:0] row,
    input  logic [SW-1:0]    cur_smp,
    input  logic [SW-1:0]    prv_smp,
    output rgb_t             pix
);
    logic [VBITS-1:0] lvl, y_cur, y_prv, lo, hi;
    logic [CH_W-1:0]  shade;
    logic             on_trace;

    generate
        if (VBITS >= CH_W) begin : g_coarse
            assign shade = row[VBITS-1 -: CH_W];
        end else begin : g_fine
            assign shade = {row, {(CH_W - VBITS){1'b0}}};
        end
    endgenerate

    always_comb begin
        lvl      = ~row;
        y_cur    = cur_smp[SW-1 -: VBITS];
        y_prv    = prv_smp[SW-1 -: VBITS];
        lo       = (y_cur < y_prv) ? y_cur : y_prv;
        hi       = (y_cur < y_prv) ? y_prv : y_cur;
        on_trace = (lvl >= lo) && (lvl <= hi);
        pix      = on_trace ? rgb_t'(TRACE) : bg_color(shade);
    end
endmodule

// File: rtl/wfr_render.sv
module wfr_render
    import wfr_pkg::*;
#(
    parameter int          AW    = 24,
    parameter int          SW    = 8,
    parameter int          H_ACT = 720,
    parameter int          VBITS = 8,
    parameter logic [11:0] TRACE = 12'hFF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] frame_base,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [SW-1:0] mem_rsp_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [11:0]   out_pix
);
    localparam int N    = H_ACT / 2;
    localparam int CBW  = $clog2(H_ACT);
    localparam int IXW  = $clog2(N);
    localparam int CNTW = $clog2(N + 1);

    typedef struct packed {
        logic             start;
        logic [CBW-1:0]   col;
        logic [VBITS-1:0] row;
        logic             valid;
        logic [11:0]      pix;
    } pix_st_t;

    pix_st_t st_d, st_q;

    logic            start_q;
    logic            wr_en;
    logic [IXW-1:0]  wr_idx;
    logic [CNTW-1:0] fill;
    logic [IXW-1:0]  s_idx, p_idx;
    logic [SW-1:0]   cur_smp, prv_smp;
    rgb_t            color;
    logic            avail, take;

    assign start_q = st_q.start;

    wfr_fetch #(.AW(AW), .N(N)) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start_q),
        .frame_base    (frame_base),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .fill          (fill)
    );

    wfr_sample_buf #(.DEPTH(N), .SW(SW)) u_buf (
        .clk    (clk),
        .we     (wr_en),
        .wa     (wr_idx),
        .wd     (mem_rsp_data),
        .ra_cur (s_idx),
        .ra_prv (p_idx),
        .rd_cur (cur_smp),
        .rd_prv (prv_smp)
    );

    wfr_pixel_color #(.VBITS(VBITS), .SW(SW), .TRACE(TRACE)) u_color (
        .row     (st_q.row),
        .cur_smp (cur_smp),
        .prv_smp (prv_smp),
        .pix     (color)
    );

    assign s_idx     = IXW'(st_q.col >> 1);
    assign p_idx     = (s_idx == '0) ? '0 : s_idx - 1'b1;
    assign avail     = CNTW'(s_idx) < fill;
    assign take      = !st_q.start && avail && (!st_q.valid || out_ready);
    assign out_valid = st_q.valid;
    assign out_pix   = st_q.pix;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (st_q.valid && out_ready) st_d.valid = 1'b0;
        if (take) begin
            st_d.valid = 1'b1;
            st_d.pix   = color;
            if (st_q.col == CBW'(H_ACT - 1)) begin
                st_d.col = '0;
                st_d.row = st_q.row + 1'b1;
                if (&st_q.row) st_d.start = 1'b1;
            end else begin
                st_d.col = st_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.start <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wfr_render_chk.sv
module wfr_render_chk #(
    parameter int AW    = 24,
    parameter int H_ACT = 720,
    parameter int VBITS = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_start,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [AW-1:0] mem_req_addr,
    input logic          mem_rsp_valid,
    input logic          out_valid,
    input logic          out_ready,
    input logic [11:0]   out_pix
);
    localparam int N     = H_ACT / 2;
    localparam int FRAME = H_ACT * (1 << VBITS);

    logic [31:0] req_cnt, rsp_cnt, pix_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_cnt <= '0;
            rsp_cnt <= '0;
            pix_cnt <= '0;
        end else begin
            if (frame_start) begin
                req_cnt <= '0;
                rsp_cnt <= '0;
            end else begin
                if (mem_req_valid && mem_req_ready) req_cnt <= req_cnt + 1;
                if (mem_rsp_valid)                  rsp_cnt <= rsp_cnt + 1;
            end
            if (out_valid && out_ready)
                pix_cnt <= (pix_cnt == 32'(FRAME - 1)) ? '0 : pix_cnt + 1;
        end
    end

    // R1
    always @(negedge clk) begin
        if (!rst_n) begin
            rst_idle_chk: assert (!out_valid && !mem_req_valid)
                else $error("reset outputs not idle");
        end
    end

    // R9
    pix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pix));

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R2
    req_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> req_cnt < 32'(N));

    // R10
    fill_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && pix_cnt < 32'(H_ACT) |-> (pix_cnt >> 1) < rsp_cnt);

    // R4
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && out_valid |-> pix_cnt == 32'(FRAME - 1));
endmodule

bind wfr_render wfr_render_chk #(.AW(AW), .H_ACT(H_ACT), .VBITS(VBITS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start   (start_q),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_pix       (out_pix)
);

// File: tb/sim_wfr_render.sv
module sim_wfr_render;
    localparam int AW    = 16;
    localparam int SW    = 8;
    localparam int H_ACT = 16;
    localparam int VBITS = 3;
    localparam int ROWS  = 1 << VBITS;
    localparam int NS    = H_ACT / 2;
    localparam int FRAME = H_ACT * ROWS;
    localparam int NFRM  = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] frame_base;
    logic          mem_req_valid, mem_req_ready;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid;
    logic [SW-1:0] mem_rsp_data;
    logic          out_valid, out_ready;
    logic [11:0]   out_pix;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int nhs    = 0;

    logic [11:0] exp_pix[$];
    int          exp_addr[$];
    int          pend_due[$];
    logic [7:0]  pend_dat[$];
    int          last_due = 0;
    logic        held_v = 1'b0;
    logic [11:0] held_pix;

    always #2 clk = ~clk;

    wfr_render #(.AW(AW), .SW(SW), .H_ACT(H_ACT), .VBITS(VBITS)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_base(frame_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_pix(out_pix)
    );

    function automatic logic [7:0] smp(input int a);
        return 8'((a * 37 + 11) % 256);
    endfunction

    // driver: expected pixels (R4..R8) and addresses (R2, R3) of one frame
    task automatic push_frame(input int base);
        for (int s = 0; s < NS; s++) exp_addr.push_back(base + s);
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < H_ACT; c++) begin
                int s, cur, prv, lvl, lo, hi;
                s   = c / 2;
                cur = smp(base + s) >> (SW - VBITS);
                prv = (s == 0) ? cur : smp(base + s - 1) >> (SW - VBITS);
                lvl = ROWS - 1 - r;
                lo  = (cur < prv) ? cur : prv;
                hi  = (cur < prv) ? prv : cur;
                if (lvl >= lo && lvl <= hi) exp_pix.push_back(12'hFF0);
                else                        exp_pix.push_back({8'h00, 4'(r * 16 / ROWS)});
            end
        end
    endtask

    // memory model: random accept, in-order responses with random latency
    always @(negedge clk) begin
        cyc++;
        mem_rsp_valid = 1'b0;
        if (rst_n) begin
            if (pend_due.size() > 0 && pend_due[0] <= cyc) begin
                void'(pend_due.pop_front());
                mem_rsp_data  = pend_dat.pop_front();
                mem_rsp_valid = 1'b1;
            end
            mem_req_ready = ($urandom % 4) != 0;
            if (mem_req_valid && mem_req_ready) begin
                int ea, due;
                ea = (exp_addr.size() > 0) ? exp_addr.pop_front() : -1;
                checks++;
                if (ea >= 0 && int'(mem_req_addr) != ea) begin
                    fails++;
                    $display("FAIL R2 R3 request address actual=%0d expected=%0d", mem_req_addr, ea);
                end
                due = cyc + 1 + ($urandom % 4);
                if (due <= last_due) due = last_due + 1;
                last_due = due;
                pend_due.push_back(due);
                pend_dat.push_back(smp(int'(mem_req_addr)));
            end
        end
    end

    // monitor: backpressure hold (R9) and pixel scoreboard (R4..R8, R10)
    always @(negedge clk) begin
        if (rst_n) begin
            if (held_v) begin
                checks++;
                if (!out_valid || out_pix != held_pix) begin
                    fails++;
                    $display("FAIL R9 held pixel actual=%0b/%h expected=1/%h", out_valid, out_pix, held_pix);
                end
            end
            out_ready = (nhs < FRAME) ? 1'b1 : (($urandom % 3) != 0);
            held_v    = out_valid && !out_ready;
            held_pix  = out_pix;
            if (out_valid && out_ready) begin
                logic [11:0] e;
                e = (exp_pix.size() > 0) ? exp_pix.pop_front() : 12'hxxx;
                checks++;
                if (out_pix !== e) begin
                    fails++;
                    if (e == 12'hFF0)
                        $display("FAIL R4 R5 R6 R7 R10 pixel %0d actual=%h expected=%h", nhs, out_pix, e);
                    else
                        $display("FAIL R4 R8 R10 pixel %0d actual=%h expected=%h", nhs, out_pix, e);
                end
                nhs++;
                if (nhs == 5)         frame_base = 16'd40;  // R3 mid-frame change, applies next frame
                if (nhs == FRAME + 3) frame_base = 16'd7;
            end
        end
    end

    initial begin
        rst_n         = 1'b0;
        frame_base    = 16'd100;
        out_ready     = 1'b0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        push_frame(100);
        push_frame(40);
        push_frame(7);
        push_frame(7);
        repeat (5) @(negedge clk);
        checks++;
        if (out_valid || mem_req_valid) begin
            fails++;
            $display("FAIL R1 reset outputs actual=%0b%0b expected=00", out_valid, mem_req_valid);
        end
        rst_n = 1'b1;
        while (nhs < NFRM * FRAME && cyc < 20000) @(negedge clk);
        if (cyc >= 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog pixels actual=%0d expected=%0d", nhs, NFRM * FRAME);
        end
        checks++;
        if (nhs != NFRM * FRAME) begin
            fails++;
            $display("FAIL R4 pixel count actual=%0d expected=%0d", nhs, NFRM * FRAME);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule